// File: doc/BRIEF.md
# Masked Peripheral Register Bank

This block holds the byte-wide control registers of a handheld console's peripheral page. The CPU reaches them through an 8-bit offset and a plain write strobe. Reads are combinational. Every defined register returns its stored byte ORed with a fixed mask of unimplemented bits, so those bits always read as 1. An offset that has no register reads as 0xFF.

Writes do not always store the CPU byte unchanged. A write to the divider stores nothing and only pulses a clear to the external divider counter. The interrupt-flag register always stores its top three bits as 1. Sound registers are zeroed and not forwarded while the sound engine is off. The length registers of the third and fourth sound channels are the exception when the legacy-compatibility parameter is set. The sound master register keeps only its enable bit from the CPU, and its low nibble tracks the channel-status input.

A synchronous reset loads each register with a power-on byte, passed through the same write filter that CPU writes use. The strobe outputs for the divider, the DMA engine, the interrupt controller and the sound engine are combinational. Each is high in the same cycle as the write that causes it.

Top module: `periph_regbank`

## Requirements
- R1: A read of a defined offset returns the stored byte ORed with that register's mask: 0x01 (LCD status) 0x80, 0x09 (serial control) 0x7E, 0x0F (timer control) 0xF8, 0x10 (interrupt flag) 0xE0, 0x11 (interrupt enable) 0xE0, 0x34 (sound master) 0x70.
- R2: A read of an offset with no register returns 0xFF. A write there raises no strobe, and the offset still reads 0xFF afterwards.
- R3: A write to 0x10 stores the byte with bits 7..5 set. A write to 0x10 or to 0x11 pulses irq_upd_o in that write cycle.
- R4: A write to 0x0C stores nothing and pulses div_clr_o in that cycle. A read of 0x0C returns tmr_div_i.
- R5: A write to 0x05 pulses dma_go_o with dma_src_o equal to the written byte in bits 15..8 and zero in bits 7..0. The byte is stored and reads back.
- R6: While snd_on_i is 0, a write to a gated sound register stores 0x00 and raises no snd_wr_o. The gated registers are 0x20..0x33, except 0x2A and 0x2E.
- R7: With LEN_COMPAT=1, a write to 0x2A or 0x2E stores the byte and pulses snd_wr_o even while snd_on_i is 0.
- R8: While snd_on_i is 1, a write to any sound register 0x20..0x33 stores the byte and pulses snd_wr_o.
- R9: A write to 0x34 keeps only bit 7 from the CPU and always pulses snd_wr_o. Bits 6..4 are stored as 0. Bits 3..0 take snd_chan_i on every clock edge.
- R10: After reset, the registers read as follows: 0x00 = 0x91, 0x02 = 0xFC, 0x03 = 0xFF, 0x04 = 0xFF, 0x10 = 0xE1, 0x11 = 0xE0, 0x21 = 0xBF, 0x32 = 0x77, and 0x34 = 0xF0 when snd_chan_i is 0.
- R11: At most one strobe is high in any cycle. No strobe is high while rst is high or outside a write cycle.
- R12: Plain registers store and return the whole byte, for example the timer modulo at 0x0E and the object palette at 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the power-on bytes |
| cpu_addr_i | input | 8 | Register offset for read and write |
| cpu_wdata_i | input | 8 | Write data |
| cpu_we_i | input | 1 | Write strobe, one byte per cycle |
| cpu_rdata_o | output | 8 | Combinational read data, masked |
| snd_on_i | input | 1 | Sound engine enabled |
| snd_chan_i | input | 4 | Live channel-active flags from the sound engine |
| tmr_div_i | input | 8 | Current divider count from the timer |
| div_clr_o | output | 1 | Divider clear pulse |
| dma_go_o | output | 1 | DMA start pulse |
| dma_src_o | output | 16 | DMA source address |
| irq_upd_o | output | 1 | Interrupt re-evaluation pulse |
| snd_wr_o | output | 1 | Sound register write forwarded to the sound engine |

## Verification
The assertions assume that snd_on_i and the CPU address and data are stable through each write cycle. If snd_on_i changed mid-write, a gated write could be judged against the wrong enable. The bench therefore changes snd_on_i, snd_chan_i and tmr_div_i only at a falling edge in cycles that carry no write. It drives every CPU access at a falling edge and holds it for one full cycle. It samples read data and strobes shortly after the following rising edge, while the access is still applied.

// File: rtl/prb_pkg.sv
`timescale 1ns/1ps
package prb_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;
    localparam int NSLOT = 1 << ADDR_W;

    typedef enum logic [2:0] {
        K_PLAIN, K_DIV, K_IRQF, K_IRQE, K_DMA, K_SND, K_SNDLEN, K_MASTER
    } reg_kind_e;

    typedef struct packed {
        logic              hit;
        reg_kind_e         kind;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] init;
    } reg_info_t;

    typedef struct packed {
        logic              store;
        logic              fwd;
        logic [DATA_W-1:0] val;
    } wr_res_t;

    localparam logic [ADDR_W-1:0] A_DMA    = 8'h05;
    localparam logic [ADDR_W-1:0] A_DIV    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_IRQF   = 8'h10;
    localparam logic [ADDR_W-1:0] A_IRQE   = 8'h11;
    localparam logic [ADDR_W-1:0] A_MASTER = 8'h34;
    localparam logic [DATA_W-1:0] IRQ_HI   = 8'hE0;

    function automatic reg_info_t mk(reg_kind_e k, logic [7:0] m, logic [7:0] i);
        reg_info_t r;
        r.hit = 1'b1; r.kind = k; r.mask = m; r.init = i;
        return r;
    endfunction

    function automatic reg_info_t prb_info(logic [ADDR_W-1:0] a);
        reg_info_t r;
        r = '0;
        case (a)
            8'h00: r = mk(K_PLAIN,  8'h00, 8'h91);
            8'h01: r = mk(K_PLAIN,  8'h80, 8'h00);
            8'h02: r = mk(K_PLAIN,  8'h00, 8'hFC);
            8'h03: r = mk(K_PLAIN,  8'h00, 8'hFF);
            8'h04: r = mk(K_PLAIN,  8'h00, 8'hFF);
            8'h05: r = mk(K_DMA,    8'h00, 8'h00);
            8'h08: r = mk(K_PLAIN,  8'h00, 8'h00);
            8'h09: r = mk(K_PLAIN,  8'h7E, 8'h00);
            8'h0C: r = mk(K_DIV,    8'h00, 8'h00);
            8'h0D: r = mk(K_PLAIN,  8'h00, 8'h00);
            8'h0E: r = mk(K_PLAIN,  8'h00, 8'h00);
            8'h0F: r = mk(K_PLAIN,  8'hF8, 8'h00);
            8'h10: r = mk(K_IRQF,   8'hE0, 8'h01);
            8'h11: r = mk(K_IRQE,   8'hE0, 8'h00);
            8'h20: r = mk(K_SND,    8'h80, 8'h80);
            8'h21: r = mk(K_SND,    8'h3F, 8'hBF);
            8'h22: r = mk(K_SND,    8'h00, 8'hF3);
            8'h23: r = mk(K_SND,    8'hFF, 8'hF3);
            8'h24: r = mk(K_SND,    8'hBF, 8'hBF);
            8'h25: r = mk(K_SND,    8'h3F, 8'h3F);
            8'h26: r = mk(K_SND,    8'h00, 8'h00);
            8'h27: r = mk(K_SND,    8'hFF, 8'h00);
            8'h28: r = mk(K_SND,    8'hBF, 8'hBF);
            8'h29: r = mk(K_SND,    8'h7F, 8'h7F);
            8'h2A: r = mk(K_SNDLEN, 8'h00, 8'hFF);
            8'h2B: r = mk(K_SND,    8'h9F, 8'h9F);
            8'h2C: r = mk(K_SND,    8'hFF, 8'h00);
            8'h2D: r = mk(K_SND,    8'hBF, 8'hBF);
            8'h2E: r = mk(K_SNDLEN, 8'h00, 8'hFF);
            8'h2F: r = mk(K_SND,    8'h00, 8'h00);
            8'h30: r = mk(K_SND,    8'h00, 8'h00);
            8'h31: r = mk(K_SND,    8'hBF, 8'hBF);
            8'h32: r = mk(K_SND,    8'h00, 8'h77);
            8'h33: r = mk(K_SND,    8'h00, 8'hF3);
            8'h34: r = mk(K_MASTER, 8'h70, 8'hF1);
            default: r = '0;
        endcase
        return r;
    endfunction

    // Shared by CPU writes and by the reset loader.
    function automatic wr_res_t prb_filter(reg_kind_e k, logic [DATA_W-1:0] d,
                                           logic snd_on, logic compat);
        wr_res_t r;
        r.store = 1'b1;
        r.fwd   = 1'b0;
        r.val   = d;
        case (k)
            K_DIV:    begin r.store = 1'b0; r.val = '0; end
            K_IRQF:   r.val = d | IRQ_HI;
            K_SND:    begin r.fwd = snd_on; r.val = snd_on ? d : '0; end
            K_SNDLEN: begin
                r.fwd = snd_on | compat;
                r.val = (snd_on | compat) ? d : '0;
            end
            K_MASTER: begin r.fwd = 1'b1; r.val = d & 8'h80; end
            default:  ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/prb_wr_policy.sv
`timescale 1ns/1ps
module prb_wr_policy
    import prb_pkg::*;
#(
    parameter bit LEN_COMPAT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              snd_on_i,
    output logic              store_en_o,
    output logic [DATA_W-1:0] store_val_o,
    output logic              div_clr_o,
    output logic              dma_go_o,
    output logic [15:0]       dma_src_o,
    output logic              irq_upd_o,
    output logic              snd_wr_o
);
    logic      hit;
    reg_kind_e kind;
    wr_res_t   res;
    logic      we_ok;

    assign hit   = prb_info(addr_i).hit;
    assign kind  = prb_info(addr_i).kind;
    assign res   = prb_filter(kind, wdata_i, snd_on_i, LEN_COMPAT);
    assign we_ok = we_i && !rst && hit;

    assign store_en_o  = we_ok && res.store;
    assign store_val_o = res.val;
    assign div_clr_o   = we_ok && (kind == K_DIV);
    assign dma_go_o    = we_ok && (kind == K_DMA);
    assign dma_src_o   = {wdata_i, 8'h00};
    assign irq_upd_o   = we_ok && (kind == K_IRQF || kind == K_IRQE);
    assign snd_wr_o    = we_ok && res.fwd;

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({div_clr_o, dma_go_o, irq_upd_o, snd_wr_o}));
    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !(div_clr_o || dma_go_o || irq_upd_o || snd_wr_o));
    // R6
    snd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (snd_wr_o && !snd_on_i) |-> (kind == K_SNDLEN || kind == K_MASTER));
endmodule

// File: rtl/prb_reg_array.sv
`timescale 1ns/1ps
module prb_reg_array
    import prb_pkg::*;
#(
    parameter bit LEN_COMPAT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              store_en_i,
    input  logic [DATA_W-1:0] store_val_i,
    input  logic [3:0]        snd_chan_i,
    output logic [DATA_W-1:0] slot_o [NSLOT]
);
    for (genvar a = 0; a < NSLOT; a++) begin : g_slot
        localparam reg_info_t INF = prb_info(ADDR_W'(a));
        localparam wr_res_t   RST = prb_filter(INF.kind, INF.init, 1'b1, LEN_COMPAT);
        logic wr_hit;
        assign wr_hit = store_en_i && (addr_i == ADDR_W'(a));

        if (INF.hit && INF.kind == K_MASTER) begin : g_master
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= RST.val;
                else     q <= {(wr_hit ? store_val_i[7] : q[7]), 3'b000, snd_chan_i};
            end
            assign slot_o[a] = q;
        end else if (INF.hit && INF.kind != K_DIV) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)         q <= RST.val;
                else if (wr_hit) q <= store_val_i;
            end
            assign slot_o[a] = q;
        end else begin : g_none
            assign slot_o[a] = '0;
        end
    end

    // R3
    irqf_top_chk: assert property (@(posedge clk) disable iff (rst)
        slot_o[A_IRQF][7:5] == 3'b111);
    // R9
    master_mid_chk: assert property (@(posedge clk) disable iff (rst)
        slot_o[A_MASTER][6:4] == 3'b000);
endmodule

// File: rtl/prb_rd_mux.sv
`timescale 1ns/1ps
module prb_rd_mux
    import prb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] slot_i [NSLOT],
    input  logic [DATA_W-1:0] tmr_div_i,
    output logic [DATA_W-1:0] rdata_o
);
    reg_info_t         info;
    logic [DATA_W-1:0] raw;

    always_comb begin
        info = prb_info(addr_i);
        raw  = (info.kind == K_DIV) ? tmr_div_i : slot_i[addr_i];
        rdata_o = info.hit ? (raw | info.mask) : '1;
    end
endmodule

// File: rtl/periph_regbank.sv
`timescale 1ns/1ps
module periph_regbank
    import prb_pkg::*;
#(
    parameter bit LEN_COMPAT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cpu_addr_i,
    input  logic [7:0]  cpu_wdata_i,
    input  logic        cpu_we_i,
    output logic [7:0]  cpu_rdata_o,
    input  logic        snd_on_i,
    input  logic [3:0]  snd_chan_i,
    input  logic [7:0]  tmr_div_i,
    output logic        div_clr_o,
    output logic        dma_go_o,
    output logic [15:0] dma_src_o,
    output logic        irq_upd_o,
    output logic        snd_wr_o
);
    logic              store_en;
    logic [DATA_W-1:0] store_val;
    logic [DATA_W-1:0] slot [NSLOT];

    prb_wr_policy #(.LEN_COMPAT(LEN_COMPAT)) u_pol (
        .clk(clk), .rst(rst), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
        .we_i(cpu_we_i), .snd_on_i(snd_on_i), .store_en_o(store_en),
        .store_val_o(store_val), .div_clr_o(div_clr_o), .dma_go_o(dma_go_o),
        .dma_src_o(dma_src_o), .irq_upd_o(irq_upd_o), .snd_wr_o(snd_wr_o)
    );

    prb_reg_array #(.LEN_COMPAT(LEN_COMPAT)) u_arr (
        .clk(clk), .rst(rst), .addr_i(cpu_addr_i), .store_en_i(store_en),
        .store_val_i(store_val), .snd_chan_i(snd_chan_i), .slot_o(slot)
    );

    prb_rd_mux u_rd (
        .addr_i(cpu_addr_i), .slot_i(slot), .tmr_div_i(tmr_div_i),
        .rdata_o(cpu_rdata_o)
    );

    // Tracks a gated sound write so the stored byte can be checked next cycle.
    logic              gate_q;
    logic [ADDR_W-1:0] gate_addr_q;
    always_ff @(posedge clk) begin
        gate_q      <= !rst && cpu_we_i && !snd_on_i && (prb_info(cpu_addr_i).kind == K_SND);
        gate_addr_q <= cpu_addr_i;
    end

    // R6
    gated_zero_chk: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> slot[gate_addr_q] == 8'h00);
    // R4
    div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_we_i && cpu_addr_i == A_DIV) |-> (div_clr_o && !snd_wr_o));
    // R2
    unk_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !prb_info(cpu_addr_i).hit |-> cpu_rdata_o == 8'hFF);
endmodule

// File: tb/sim_periph_regbank.sv
`timescale 1ns/1ps
module sim_periph_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_addr_i = '0;
    logic [7:0]  cpu_wdata_i = '0;
    logic        cpu_we_i = 1'b0;
    logic [7:0]  cpu_rdata_o;
    logic        snd_on_i = 1'b1;
    logic [3:0]  snd_chan_i = '0;
    logic [7:0]  tmr_div_i = '0;
    logic        div_clr_o, dma_go_o, irq_upd_o, snd_wr_o;
    logic [15:0] dma_src_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    periph_regbank u0 (
        .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_we_i(cpu_we_i), .cpu_rdata_o(cpu_rdata_o), .snd_on_i(snd_on_i),
        .snd_chan_i(snd_chan_i), .tmr_div_i(tmr_div_i), .div_clr_o(div_clr_o),
        .dma_go_o(dma_go_o), .dma_src_o(dma_src_o), .irq_upd_o(irq_upd_o),
        .snd_wr_o(snd_wr_o)
    );

    typedef struct {
        bit          is_rd;
        logic [7:0]  exp_rd;
        logic [3:0]  exp_stb;
        logic [15:0] exp_src;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t it;

    // Strobe vector order: {div, dma, irq, snd}
    task automatic wr(input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] stb, input string tag);
        item_t x;
        @(negedge clk);
        cpu_addr_i = a; cpu_wdata_i = d; cpu_we_i = 1'b1;
        x.is_rd = 1'b0; x.exp_rd = '0; x.exp_stb = stb;
        x.exp_src = {d, 8'h00}; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t x;
        @(negedge clk);
        cpu_addr_i = a; cpu_we_i = 1'b0;
        x.is_rd = 1'b1; x.exp_rd = e; x.exp_stb = '0; x.exp_src = '0; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_we_i = 1'b0;
    endtask

    // Monitor: one sample per cycle, after the rising edge.
    initial forever begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (it.is_rd) begin
                if (cpu_rdata_o !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", it.tag, cpu_rdata_o, it.exp_rd);
                end
            end else begin
                if ({div_clr_o, dma_go_o, irq_upd_o, snd_wr_o} !== it.exp_stb) begin
                    errors++;
                    $display("FAIL %s: strobes actual=%b expected=%b", it.tag,
                             {div_clr_o, dma_go_o, irq_upd_o, snd_wr_o}, it.exp_stb);
                end else if (it.exp_stb[2] && dma_src_o !== it.exp_src) begin
                    errors++;
                    $display("FAIL %s: dma_src actual=%h expected=%h", it.tag, dma_src_o, it.exp_src);
                end
            end
        end
    end

    initial begin
        #80000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: no strobe while in reset, even with a write applied
        cpu_addr_i = 8'h0C; cpu_we_i = 1'b1;
        @(posedge clk); #1;
        checks++;
        if ({div_clr_o, dma_go_o, irq_upd_o, snd_wr_o} !== 4'b0000) begin
            errors++;
            $display("FAIL R11 reset strobes: actual=%b expected=0000",
                     {div_clr_o, dma_go_o, irq_upd_o, snd_wr_o});
        end
        @(negedge clk);
        cpu_we_i = 1'b0; rst = 1'b0;

        // R10 reset values
        rd(8'h00, 8'h91, "R10 lcd ctrl");
        rd(8'h02, 8'hFC, "R10 bg palette");
        rd(8'h03, 8'hFF, "R10 obj palette 0");
        rd(8'h04, 8'hFF, "R10 obj palette 1");
        rd(8'h10, 8'hE1, "R10 irq flag");
        rd(8'h11, 8'hE0, "R10 irq enable");
        rd(8'h21, 8'hBF, "R10 ch1 length");
        rd(8'h32, 8'h77, "R10 volume");
        rd(8'h34, 8'hF0, "R10 sound master");

        // R1 masks
        wr(8'h09, 8'h00, 4'b0000, "R1 serial ctrl write");
        rd(8'h09, 8'h7E, "R1 serial ctrl mask");
        wr(8'h0F, 8'h05, 4'b0000, "R1 timer ctrl write");
        rd(8'h0F, 8'hFD, "R1 timer ctrl mask");
        wr(8'h01, 8'h05, 4'b0000, "R1 lcd status write");
        rd(8'h01, 8'h85, "R1 lcd status mask");

        // R12 plain full-byte registers
        wr(8'h0E, 8'h5A, 4'b0000, "R12 timer modulo write");
        rd(8'h0E, 8'h5A, "R12 timer modulo");
        wr(8'h03, 8'h1B, 4'b0000, "R12 palette write");
        rd(8'h03, 8'h1B, "R12 palette");

        // R2 undefined offsets
        rd(8'h40, 8'hFF, "R2 unknown read");
        wr(8'h40, 8'h00, 4'b0000, "R2 unknown write no strobe");
        rd(8'h40, 8'hFF, "R2 unknown after write");
        rd(8'hFF, 8'hFF, "R2 top offset");

        // R3 interrupt flag and enable
        wr(8'h10, 8'h05, 4'b0010, "R3 irq flag write strobe");
        rd(8'h10, 8'hE5, "R3 irq flag forced high");
        wr(8'h11, 8'h03, 4'b0010, "R3 irq enable write strobe");
        rd(8'h11, 8'hE3, "R1 irq enable mask");

        // R4 divider
        idle(); tmr_div_i = 8'h3C;
        wr(8'h0C, 8'h99, 4'b1000, "R4 divider clear strobe");
        rd(8'h0C, 8'h3C, "R4 divider read");
        idle(); tmr_div_i = 8'hC3;
        rd(8'h0C, 8'hC3, "R4 divider follows timer");

        // R5 DMA
        wr(8'h05, 8'hC1, 4'b0100, "R5 dma start");
        rd(8'h05, 8'hC1, "R5 dma stored");

        // R8 sound on
        wr(8'h22, 8'hA5, 4'b0001, "R8 envelope write");
        rd(8'h22, 8'hA5, "R8 envelope stored");
        wr(8'h2B, 8'h20, 4'b0001, "R8 level write");
        rd(8'h2B, 8'hBF, "R8 level stored");

        // R6 sound off: gated writes store zero
        idle(); snd_on_i = 1'b0;
        wr(8'h22, 8'h5A, 4'b0000, "R6 envelope gated");
        rd(8'h22, 8'h00, "R6 envelope zeroed");
        wr(8'h2B, 8'h40, 4'b0000, "R6 level gated");
        rd(8'h2B, 8'h9F, "R6 level zeroed");
        wr(8'h32, 8'h11, 4'b0000, "R6 volume gated");
        rd(8'h32, 8'h00, "R6 volume zeroed");

        // R7 length exceptions
        wr(8'h2A, 8'h66, 4'b0001, "R7 ch3 length forwarded");
        rd(8'h2A, 8'h66, "R7 ch3 length stored");
        wr(8'h2E, 8'h12, 4'b0001, "R7 ch4 length forwarded");
        rd(8'h2E, 8'h12, "R7 ch4 length stored");

        // R9 sound master
        idle(); snd_chan_i = 4'hA;
        wr(8'h34, 8'h7F, 4'b0001, "R9 master write strobe");
        rd(8'h34, 8'h7A, "R9 master bit7 cleared");
        wr(8'h34, 8'h80, 4'b0001, "R9 master write set");
        rd(8'h34, 8'hFA, "R9 master bit7 set");

        idle(); idle(); idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule